// File: doc/BRIEF.md
# Two-Level Interrupt Cause Aggregator

This block gathers single-cycle event pulses from a communication subsystem into a bank of second-level cause registers. Each cause bit latches its event and holds it until software acknowledges it by writing a zero to that bit. Every cause register also feeds one bit in each of two read-only summary registers, a high summary and a serial summary. A summary bit follows its cause bits without any action from software, so it clears as soon as the cause bits behind it have been acknowledged.

Four active-low interrupt lines are driven from the summaries through mask registers. The two main lines each have two masks, one over the high summary and one over the serial summary. The two serial lines each have one mask over the serial summary. Software reaches every register through a simple synchronous port: a write strobe with address and data, and read data returned one cycle after the address is presented. All register addresses are set by parameters.

Top module: `irq_cause_agg`

## Requirements
- R1: An event pulse on `evt_i[k*CAUSE_W+b]` sets bit b of cause register k at the next clock edge, and the bit reads back as 1.
- R2: A set cause bit stays set until a write to its register carries 0 in that bit position. Writing 1 to a cause bit leaves it unchanged, whether it is set or clear.
- R3: When an event pulse and a write of 0 hit the same cause bit in the same cycle, the bit ends up at 1.
- R4: With the default fold mode (SUM_MODE=0), high summary bit k is the OR of cause register k bits [SPLIT-1:0], and serial summary bit k is the OR of bits [CAUSE_W-1:SPLIT]. Each summary bit clears by itself once those cause bits are acknowledged.
- R5: Writes to either summary address have no effect on the summary values.
- R6: A mask bit at 1 passes its summary bit and a 0 blocks it. `int0_n_o` is low when (high summary AND mask MASK_BASE+0) OR (serial summary AND mask MASK_BASE+1) is non-zero. `int1_n_o` does the same with masks MASK_BASE+2 and MASK_BASE+3. `serint0_n_o` and `serint1_n_o` are low when the serial summary AND mask MASK_BASE+4 or MASK_BASE+5, respectively, is non-zero.
- R7: The interrupt outputs are registered. An output changes one clock edge after the cause or mask change that moves it.
- R8: After reset all cause and mask bits are 0, all four interrupt outputs are high, and the registers read 0.
- R9: `rdata_o` returns, one cycle after `addr_i` is presented, cause register k at CAUSE_BASE+k, the high summary at HSUM_ADDR, the serial summary at SSUM_ADDR, and the six masks at MASK_BASE+0 to MASK_BASE+5. Values are zero-extended.
- R10: Addresses outside these windows read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_CAUSE*CAUSE_W | Event pulses; slice k feeds cause register k |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address for read and write |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, one cycle after the address |
| int0_n_o | output | 1 | Main interrupt line 0, active low |
| int1_n_o | output | 1 | Main interrupt line 1, active low |
| serint0_n_o | output | 1 | Serial interrupt line 0, active low |
| serint1_n_o | output | 1 | Serial interrupt line 1, active low |

## Verification
The two functions that can land in the same cycle are the latching of a new event and the software acknowledge that clears a cause bit. The bench provokes this by driving an event pulse on a bit that is already pending, together with a write of zero to the same register, on one clock edge. It also pulses a neighbouring bit that was clear. The result is judged by reading the register back: both bits must be 1. A second contention, a summary write racing the summary's own update, is judged by checking that the read value still tracks the cause bits.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // Order of the mask registers above MASK_BASE; the output stage decodes it.
   typedef enum logic [2:0] {
      MSK_I0_HI  = 3'd0,
      MSK_I0_SER = 3'd1,
      MSK_I1_HI  = 3'd2,
      MSK_I1_SER = 3'd3,
      MSK_S0_SER = 3'd4,
      MSK_S1_SER = 3'd5
   } mask_sel_e;

   localparam int NUM_MASKS = 6;
   localparam int NUM_LINES = 4;

   // Output line indices inside the registered line vector.
   localparam int LINE_I0 = 0;
   localparam int LINE_I1 = 1;
   localparam int LINE_S0 = 2;
   localparam int LINE_S1 = 3;

   // Summary fold variants.
   localparam int FOLD_SPLIT = 0;
   localparam int FOLD_BOTH  = 1;

   function automatic bit windows_overlap(int a_base, int a_len, int b_base, int b_len);
      return (a_base < b_base + b_len) && (b_base < a_base + a_len);
   endfunction

endpackage

// File: rtl/irq_agg_cause_bank.sv
module irq_agg_cause_bank #(
   parameter int N_CAUSE    = 16,
   parameter int CAUSE_W    = 16,
   parameter int AW         = 8,
   parameter int CAUSE_BASE = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              addr,
   input  logic [CAUSE_W-1:0]         wbits,
   input  logic [N_CAUSE*CAUSE_W-1:0] evt,
   output logic [N_CAUSE*CAUSE_W-1:0] cause
);

   localparam int FLAT_W = N_CAUSE * CAUSE_W;

   if (N_CAUSE < 1) begin : g_bad_count
      $error("irq_agg_cause_bank: N_CAUSE must be at least 1");
   end
   if (CAUSE_BASE + N_CAUSE > (1 << AW)) begin : g_bad_window
      $error("irq_agg_cause_bank: cause window exceeds address space");
   end

   for (genvar k = 0; k < N_CAUSE; k++) begin : g_reg
      localparam logic [AW-1:0] MY_ADDR = AW'(CAUSE_BASE + k);

      logic               hit;
      logic [CAUSE_W-1:0] cur_q;
      logic [CAUSE_W-1:0] keep;
      logic [CAUSE_W-1:0] nxt;

      assign hit  = wr_en && (addr == MY_ADDR);
      // Acknowledge: a zero in the write data drops that bit; a one keeps it.
      assign keep = hit ? (cur_q & wbits) : cur_q;
      // New events are ORed in after the acknowledge, so a set always wins.
      assign nxt  = keep | evt[k*CAUSE_W +: CAUSE_W];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cur_q <= '0;
         end else begin
            cur_q <= nxt;
         end
      end

      assign cause[k*CAUSE_W +: CAUSE_W] = cur_q;
   end

   logic unused_width_tie;
   assign unused_width_tie = (FLAT_W == 0);

endmodule

// File: rtl/irq_agg_summary.sv
module irq_agg_summary
   import irq_agg_pkg::*;
#(
   parameter int N_CAUSE  = 16,
   parameter int CAUSE_W  = 16,
   parameter int SPLIT    = 8,
   parameter int SUM_MODE = FOLD_SPLIT
) (
   input  logic [N_CAUSE*CAUSE_W-1:0] cause,
   output logic [N_CAUSE-1:0]         hsum,
   output logic [N_CAUSE-1:0]         ssum
);

   localparam int HI_W  = SPLIT;
   localparam int SER_W = CAUSE_W - SPLIT;

   if (SUM_MODE != FOLD_SPLIT && SUM_MODE != FOLD_BOTH) begin : g_bad_mode
      $error("irq_agg_summary: unknown SUM_MODE");
   end
   if (SUM_MODE == FOLD_SPLIT && (SPLIT < 1 || SPLIT > CAUSE_W - 1)) begin : g_bad_split
      $error("irq_agg_summary: SPLIT must leave bits on both sides");
   end

   for (genvar k = 0; k < N_CAUSE; k++) begin : g_fold
      logic [CAUSE_W-1:0] slice;
      assign slice = cause[k*CAUSE_W +: CAUSE_W];

      if (SUM_MODE == FOLD_SPLIT) begin : g_split
         // Low part folds into the high summary, upper part into the serial one.
         assign hsum[k] = |slice[HI_W-1:0];
         assign ssum[k] = |slice[CAUSE_W-1:CAUSE_W-SER_W];
      end else begin : g_both
         // Every cause bit reaches both summaries.
         assign hsum[k] = |slice;
         assign ssum[k] = |slice;
      end
   end

endmodule

// File: rtl/irq_agg_lines.sv
module irq_agg_lines
   import irq_agg_pkg::*;
#(
   parameter int N_CAUSE   = 16,
   parameter int AW        = 8,
   parameter int MASK_BASE = 24
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [AW-1:0]                addr,
   input  logic [N_CAUSE-1:0]           wbits,
   input  logic [N_CAUSE-1:0]           hsum,
   input  logic [N_CAUSE-1:0]           ssum,
   output logic [NUM_MASKS*N_CAUSE-1:0] masks,
   output logic [NUM_LINES-1:0]         line_n
);

   if (MASK_BASE + NUM_MASKS > (1 << AW)) begin : g_bad_window
      $error("irq_agg_lines: mask window exceeds address space");
   end

   logic [N_CAUSE-1:0] m [NUM_MASKS];

   for (genvar j = 0; j < NUM_MASKS; j++) begin : g_mask
      localparam logic [AW-1:0] MY_ADDR = AW'(MASK_BASE + j);
      logic [N_CAUSE-1:0] q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && addr == MY_ADDR) begin
            q <= wbits;
         end
      end

      assign m[j] = q;
      assign masks[j*N_CAUSE +: N_CAUSE] = q;
   end

   logic [NUM_LINES-1:0] pend;

   always_comb begin
      pend[LINE_I0] = |(hsum & m[MSK_I0_HI]) | |(ssum & m[MSK_I0_SER]);
      pend[LINE_I1] = |(hsum & m[MSK_I1_HI]) | |(ssum & m[MSK_I1_SER]);
      pend[LINE_S0] = |(ssum & m[MSK_S0_SER]);
      pend[LINE_S1] = |(ssum & m[MSK_S1_SER]);
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic q_n;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_n <= 1'b1;
         end else begin
            q_n <= ~pend[i];
         end
      end
      assign line_n[i] = q_n;
   end

endmodule

// File: rtl/irq_agg_readback.sv
module irq_agg_readback
   import irq_agg_pkg::*;
#(
   parameter int N_CAUSE    = 16,
   parameter int CAUSE_W    = 16,
   parameter int DW         = 32,
   parameter int AW         = 8,
   parameter int CAUSE_BASE = 0,
   parameter int HSUM_ADDR  = 16,
   parameter int SSUM_ADDR  = 17,
   parameter int MASK_BASE  = 24
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [AW-1:0]                addr,
   input  logic [N_CAUSE*CAUSE_W-1:0]   cause,
   input  logic [N_CAUSE-1:0]           hsum,
   input  logic [N_CAUSE-1:0]           ssum,
   input  logic [NUM_MASKS*N_CAUSE-1:0] masks,
   output logic [DW-1:0]                rdata
);

   localparam logic [AW-1:0] HS_A = AW'(HSUM_ADDR);
   localparam logic [AW-1:0] SS_A = AW'(SSUM_ADDR);

   logic [DW-1:0] sel;

   always_comb begin
      sel = '0;
      for (int k = 0; k < N_CAUSE; k++) begin
         if (addr == AW'(CAUSE_BASE + k)) begin
            sel = DW'(cause[k*CAUSE_W +: CAUSE_W]);
         end
      end
      for (int j = 0; j < NUM_MASKS; j++) begin
         if (addr == AW'(MASK_BASE + j)) begin
            sel = DW'(masks[j*N_CAUSE +: N_CAUSE]);
         end
      end
      if (addr == HS_A) begin
         sel = DW'(hsum);
      end
      if (addr == SS_A) begin
         sel = DW'(ssum);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         rdata <= sel;
      end
   end

endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
   import irq_agg_pkg::*;
#(
   parameter int N_CAUSE    = 16,
   parameter int CAUSE_W    = 16,
   parameter int SPLIT      = 8,
   parameter int SUM_MODE   = FOLD_SPLIT,
   parameter int DW         = 32,
   parameter int AW         = 8,
   parameter int CAUSE_BASE = 0,
   parameter int HSUM_ADDR  = 16,
   parameter int SSUM_ADDR  = 17,
   parameter int MASK_BASE  = 24
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_CAUSE*CAUSE_W-1:0] evt_i,
   input  logic                       wr_en_i,
   input  logic [AW-1:0]              addr_i,
   input  logic [DW-1:0]              wdata_i,
   output logic [DW-1:0]              rdata_o,
   output logic                       int0_n_o,
   output logic                       int1_n_o,
   output logic                       serint0_n_o,
   output logic                       serint1_n_o
);

   localparam int FLAT_W = N_CAUSE * CAUSE_W;
   localparam int MASK_FLAT_W = NUM_MASKS * N_CAUSE;

   // Elaboration-time parameter checks.
   if (CAUSE_W > DW) begin : g_bad_cw
      $error("irq_cause_agg: CAUSE_W wider than data bus");
   end
   if (N_CAUSE > DW) begin : g_bad_nc
      $error("irq_cause_agg: summary wider than data bus");
   end
   if (HSUM_ADDR == SSUM_ADDR) begin : g_bad_sum
      $error("irq_cause_agg: summary addresses collide");
   end
   if (windows_overlap(CAUSE_BASE, N_CAUSE, MASK_BASE, NUM_MASKS)) begin : g_bad_cm
      $error("irq_cause_agg: cause and mask windows overlap");
   end
   if (windows_overlap(CAUSE_BASE, N_CAUSE, HSUM_ADDR, 1) ||
       windows_overlap(CAUSE_BASE, N_CAUSE, SSUM_ADDR, 1) ||
       windows_overlap(MASK_BASE, NUM_MASKS, HSUM_ADDR, 1) ||
       windows_overlap(MASK_BASE, NUM_MASKS, SSUM_ADDR, 1)) begin : g_bad_sw
      $error("irq_cause_agg: summary address inside a register window");
   end
   if (HSUM_ADDR >= (1 << AW) || SSUM_ADDR >= (1 << AW)) begin : g_bad_sa
      $error("irq_cause_agg: summary address out of range");
   end

   logic [FLAT_W-1:0]      cause_w;
   logic [N_CAUSE-1:0]     hsum_w;
   logic [N_CAUSE-1:0]     ssum_w;
   logic [MASK_FLAT_W-1:0] masks_w;
   logic [NUM_LINES-1:0]   line_n_w;

   irq_agg_cause_bank #(
      .N_CAUSE    (N_CAUSE),
      .CAUSE_W    (CAUSE_W),
      .AW         (AW),
      .CAUSE_BASE (CAUSE_BASE)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en_i),
      .addr  (addr_i),
      .wbits (wdata_i[CAUSE_W-1:0]),
      .evt   (evt_i),
      .cause (cause_w)
   );

   irq_agg_summary #(
      .N_CAUSE  (N_CAUSE),
      .CAUSE_W  (CAUSE_W),
      .SPLIT    (SPLIT),
      .SUM_MODE (SUM_MODE)
   ) u_sum (
      .cause (cause_w),
      .hsum  (hsum_w),
      .ssum  (ssum_w)
   );

   irq_agg_lines #(
      .N_CAUSE   (N_CAUSE),
      .AW        (AW),
      .MASK_BASE (MASK_BASE)
   ) u_lines (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en_i),
      .addr   (addr_i),
      .wbits  (wdata_i[N_CAUSE-1:0]),
      .hsum   (hsum_w),
      .ssum   (ssum_w),
      .masks  (masks_w),
      .line_n (line_n_w)
   );

   irq_agg_readback #(
      .N_CAUSE    (N_CAUSE),
      .CAUSE_W    (CAUSE_W),
      .DW         (DW),
      .AW         (AW),
      .CAUSE_BASE (CAUSE_BASE),
      .HSUM_ADDR  (HSUM_ADDR),
      .SSUM_ADDR  (SSUM_ADDR),
      .MASK_BASE  (MASK_BASE)
   ) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr_i),
      .cause (cause_w),
      .hsum  (hsum_w),
      .ssum  (ssum_w),
      .masks (masks_w),
      .rdata (rdata_o)
   );

   assign int0_n_o    = line_n_w[LINE_I0];
   assign int1_n_o    = line_n_w[LINE_I1];
   assign serint0_n_o = line_n_w[LINE_S0];
   assign serint1_n_o = line_n_w[LINE_S1];

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk #(
   parameter int N_CAUSE    = 16,
   parameter int CAUSE_W    = 16,
   parameter int AW         = 8,
   parameter int DW         = 32,
   parameter int CAUSE_BASE = 0,
   parameter int NMASK      = 6
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [AW-1:0]              addr,
   input logic [DW-1:0]              wdata,
   input logic [N_CAUSE*CAUSE_W-1:0] evt,
   input logic [N_CAUSE*CAUSE_W-1:0] cause,
   input logic [N_CAUSE-1:0]         hsum,
   input logic [N_CAUSE-1:0]         ssum,
   input logic [NMASK*N_CAUSE-1:0]   masks,
   input logic                       int0_n,
   input logic                       int1_n,
   input logic                       serint0_n,
   input logic                       serint1_n
);

   // Bits a write in this cycle is allowed to drop.
   logic [N_CAUSE*CAUSE_W-1:0] ack_allowed;
   always_comb begin
      ack_allowed = '0;
      for (int k = 0; k < N_CAUSE; k++) begin
         if (wr_en && addr == AW'(CAUSE_BASE + k)) begin
            ack_allowed[k*CAUSE_W +: CAUSE_W] = ~wdata[CAUSE_W-1:0];
         end
      end
   end

   logic all_high;
   assign all_high = int0_n && int1_n && serint0_n && serint1_n;

   // R2
   cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(cause) & ~$past(ack_allowed) & ~cause) == '0));

   // R1 R3
   event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause & $past(evt)) == $past(evt)));

   // R4
   summary_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cause) == (|(hsum | ssum))));

   // R6
   masks_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (masks == '0) |=> all_high);

   // R7
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cause == '0) |=> all_high);

endmodule

bind irq_cause_agg irq_cause_agg_chk #(
   .N_CAUSE    (N_CAUSE),
   .CAUSE_W    (CAUSE_W),
   .AW         (AW),
   .DW         (DW),
   .CAUSE_BASE (CAUSE_BASE),
   .NMASK      (irq_agg_pkg::NUM_MASKS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en_i),
   .addr      (addr_i),
   .wdata     (wdata_i),
   .evt       (evt_i),
   .cause     (cause_w),
   .hsum      (hsum_w),
   .ssum      (ssum_w),
   .masks     (masks_w),
   .int0_n    (int0_n_o),
   .int1_n    (int1_n_o),
   .serint0_n (serint0_n_o),
   .serint1_n (serint1_n_o)
);

// File: tb/tb_irq_cause_agg.sv
`timescale 1ns/1ps
module tb_irq_cause_agg;

   localparam int NC   = 16;
   localparam int CW   = 16;
   localparam int DW   = 32;
   localparam int AW   = 8;
   localparam int HS_A = 16;
   localparam int SS_A = 17;
   localparam int MB   = 24;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NC*CW-1:0] evt = '0;
   logic             wr_en = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [DW-1:0]    wdata = '0;
   logic [DW-1:0]    rdata;
   logic             int0_n, int1_n, serint0_n, serint1_n;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;

   always #5 clk = ~clk;

   irq_cause_agg dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .wr_en_i     (wr_en),
      .addr_i      (addr),
      .wdata_i     (wdata),
      .rdata_o     (rdata),
      .int0_n_o    (int0_n),
      .int1_n_o    (int1_n),
      .serint0_n_o (serint0_n),
      .serint1_n_o (serint1_n)
   );

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_write(int a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic do_read(int a, output logic [DW-1:0] v);
      @(negedge clk);
      addr = AW'(a);
      @(negedge clk);
      v = rdata;
   endtask

   task automatic pulse_evt(int k, logic [CW-1:0] bits);
      @(negedge clk);
      evt[k*CW +: CW] = bits;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      chk("R8 lines high", DW'({int0_n, int1_n, serint0_n, serint1_n}), DW'(4'hF));
      do_read(0, v);      chk("R8 cause0", v, 0);
      do_read(MB, v);     chk("R8 mask0", v, 0);
      do_read(HS_A, v);   chk("R8 hsum", v, 0);
   endtask

   task automatic t_set_hold();
      logic [DW-1:0] v;
      pulse_evt(3, 16'h0002);
      do_read(3, v);  chk("R1 cause3 set", v, 32'h2);
      do_write(3, 32'hFFFF_FFFF);
      do_read(3, v);  chk("R2 write ones keeps", v, 32'h2);
      do_write(3, 32'hFFFF_FFFD);
      do_read(3, v);  chk("R2 write zero acks", v, 32'h0);
   endtask

   task automatic t_summary();
      logic [DW-1:0] v;
      pulse_evt(5, 16'h1001);
      do_read(HS_A, v); chk("R4 hsum bit5", v, 32'h20);
      do_read(SS_A, v); chk("R4 ssum bit5", v, 32'h20);
      do_write(HS_A, 32'h0);
      do_write(SS_A, 32'hFFFF);
      do_read(HS_A, v); chk("R5 hsum ignores write", v, 32'h20);
      do_read(SS_A, v); chk("R5 ssum ignores write", v, 32'h20);
      do_write(5, 32'hFFFE);
      do_read(HS_A, v); chk("R4 hsum self clears", v, 32'h0);
      do_read(SS_A, v); chk("R4 ssum still set", v, 32'h20);
      do_write(5, 32'h0);
      do_read(SS_A, v); chk("R4 ssum self clears", v, 32'h0);
   endtask

   task automatic t_lines();
      logic [DW-1:0] v;
      pulse_evt(2, 16'h0008);              // high-side bit of cause 2
      @(negedge clk);
      chk("R6 masked lines high", DW'({int0_n, int1_n, serint0_n, serint1_n}), DW'(4'hF));
      do_write(MB + 0, 32'h4);
      chk("R7 int0 not yet", DW'(int0_n), 1);
      @(negedge clk);
      chk("R6 int0 asserted", DW'(int0_n), 0);
      chk("R6 int1 idle", DW'(int1_n), 1);
      do_write(MB + 5, 32'h4);
      @(negedge clk);
      chk("R6 serint1 blocked by empty ssum", DW'(serint1_n), 1);
      pulse_evt(9, 16'h0400);              // serial-side bit of cause 9
      do_write(MB + 3, 32'h200);
      @(negedge clk);
      chk("R6 int1 via serial mask", DW'(int1_n), 0);
      do_write(MB + 4, 32'h200);
      @(negedge clk);
      chk("R6 serint0 asserted", DW'(serint0_n), 0);
      do_read(MB + 3, v); chk("R9 mask readback", v, 32'h200);
      do_write(2, 32'h0);
      chk("R7 int0 held one cycle", DW'(int0_n), 0);
      @(negedge clk);
      chk("R6 int0 released", DW'(int0_n), 1);
      do_write(9, 32'h0);
      @(negedge clk);
      chk("R6 all released", DW'({int0_n, int1_n, serint0_n, serint1_n}), DW'(4'hF));
   endtask

   task automatic t_race();
      logic [DW-1:0] v;
      pulse_evt(7, 16'h0010);
      @(negedge clk);
      evt[7*CW +: CW] = 16'h0030;
      wr_en = 1'b1; addr = AW'(7); wdata = '0;
      @(negedge clk);
      evt = '0; wr_en = 1'b0;
      do_read(7, v); chk("R3 set beats ack", v, 32'h30);
      do_write(7, 32'h0);
      do_read(7, v); chk("R2 cleared after race", v, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [DW-1:0] v;
      do_write(8'h40, 32'hFFFF_FFFF);
      do_read(8'h40, v); chk("R10 unmapped reads zero", v, 0);
      do_read(MB + 1, v); chk("R10 masks untouched", v, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_hold();
      t_summary();
      t_lines();
      t_race();
      t_unmapped();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule